// File: doc/BRIEF.md
# Charge Status LED Pattern Generator

This block turns a cell's charge status into a drive pattern for one open-drain indicator LED. The charger's state machine supplies a 2-bit status code, and a board-level strap supplies a 2-bit display-mode select. From these two inputs the block chooses one of five patterns: dark, steadily lit, a long blink, a medium blink or a fast blink. It then drives two complementary outputs. One enables the pad's pull-low transistor. The other marks the pad as high-impedance.

All blink timing is counted in units of 0.16 s. The units come from a single-cycle tick input generated elsewhere on the chip, so the block holds no knowledge of the system clock frequency. Each cell gets its own instance. Whenever the selected pattern changes, the cadence restarts at the beginning of its lit portion, so the indicator responds to a status change without delay.

Top module: `charge_led_pattern`

## Requirements
- R1: Status code 0 (no cell present) keeps the LED dark (`ledHiZ`=1, `ledPullLow`=0) in every display mode.
- R2: `ledPullLow` and `ledHiZ` are always complements of each other.
- R3: In display mode 0, status 1 (charging) is steadily lit. Status 2 (maintenance) blinks 5 units lit then 1 unit dark. Status 3 (fault) blinks 3 units lit then 3 units dark.
- R4: In display mode 1, charging is steadily lit, maintenance is dark, and fault blinks 1 unit lit then 1 unit dark.
- R5: In display mode 2, charging blinks 5 units lit then 1 unit dark, maintenance is steadily lit, and fault blinks 1 unit lit then 1 unit dark.
- R6: Display-mode code 3 is treated exactly as mode 1.
- R7: The blink phase advances by one unit only in a cycle where `tickUnit` is high. Without a tick, the output holds its value.
- R8: Any change of status or display mode restarts the pattern at the first lit unit. The change takes priority over a tick in the same cycle.
- R9: While reset is asserted, the LED is dark. After reset, the outputs reflect the inputs sampled at the preceding clock edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tickUnit | input | 1 | Single-cycle strobe, one per 0.16 s time unit |
| statusIn | input | 2 | Charge status: 0 none, 1 charging, 2 maintenance, 3 fault |
| dispMode | input | 2 | Display-mode select, 0 to 2 (3 acts as 1) |
| ledPullLow | output | 1 | Enable for the pad's pull-low driver (LED lit) |
| ledHiZ | output | 1 | Pad released to high impedance (LED dark) |

## Verification
Several properties are checked on every cycle by assertions:
- the two outputs stay complementary;
- the steady mappings for an empty slot, for charging in mode 0 and for maintenance in modes 1, 2 and 3 hold;
- the output holds across a cycle with no tick and no input change;
- a fresh change to fault starts lit.

The exact blink cadences (5/1, 3/3 and 1/1 units), their wrap-around, and the priority of a change over a coincident tick can only be shown by the bench scenarios. These run an independent per-cycle model of phase and pattern under directed sweeps of every status and mode pair and under long random sequences of ticks and changes.

// File: rtl/ledpat_pkg.sv
package ledpat_pkg;

  typedef enum logic [1:0] {
    ST_NONE   = 2'd0,
    ST_CHARGE = 2'd1,
    ST_MAINT  = 2'd2,
    ST_FAULT  = 2'd3
  } chgStatus_e;

  typedef enum logic [2:0] {
    PAT_DARK = 3'd0,
    PAT_LIT  = 3'd1,
    PAT_LONG = 3'd2,
    PAT_MED  = 3'd3,
    PAT_FAST = 3'd4
  } pattern_e;

  typedef struct packed {
    logic     restart;
    logic     advance;
    pattern_e pattern;
  } ledStrobe_t;

endpackage

// File: rtl/ledpat_ctrl.sv
module ledpat_ctrl
  import ledpat_pkg::*;
#(
  parameter int STATUS_W = 2,
  parameter int MODE_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tickUnit,
  input  logic [STATUS_W-1:0] statusIn,
  input  logic [MODE_W-1:0]   dispMode,
  output ledStrobe_t          strobe
);

  localparam int SEL_W = STATUS_W + MODE_W;

  logic [SEL_W-1:0] selCur;
  logic [SEL_W-1:0] selReg;
  logic [MODE_W-1:0] effMode;
  pattern_e patCur;

  assign selCur = {dispMode, statusIn};

  // Mode code 3 (undriven strap read) folds onto mode 1
  always_comb begin
    effMode = dispMode;
    if (dispMode == MODE_W'(3)) effMode = MODE_W'(1);
  end

  always_comb begin
    patCur = PAT_DARK;
    unique case (chgStatus_e'(statusIn))
      ST_NONE:   patCur = PAT_DARK;
      ST_CHARGE: patCur = (effMode == MODE_W'(2)) ? PAT_LONG : PAT_LIT;
      ST_MAINT: begin
        if (effMode == MODE_W'(0))      patCur = PAT_LONG;
        else if (effMode == MODE_W'(1)) patCur = PAT_DARK;
        else                            patCur = PAT_LIT;
      end
      ST_FAULT:  patCur = (effMode == MODE_W'(0)) ? PAT_MED : PAT_FAST;
      default:   patCur = PAT_DARK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) selReg <= '0;
    else        selReg <= selCur;
  end

  always_comb begin
    strobe.restart = (selCur != selReg);
    strobe.advance = tickUnit & ~strobe.restart;
    strobe.pattern = patCur;
  end

endmodule

// File: rtl/ledpat_dp.sv
module ledpat_dp
  import ledpat_pkg::*;
#(
  parameter int LONG_LOW = 5,
  parameter int LONG_GAP = 1,
  parameter int MED_LOW  = 3,
  parameter int MED_GAP  = 3,
  parameter int FAST_LOW = 1,
  parameter int FAST_GAP = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  ledStrobe_t strobe,
  output logic       ledLow
);

  localparam int LONG_PER = LONG_LOW + LONG_GAP;
  localparam int MED_PER  = MED_LOW + MED_GAP;
  localparam int FAST_PER = FAST_LOW + FAST_GAP;
  localparam int MAX_A    = (LONG_PER > MED_PER) ? LONG_PER : MED_PER;
  localparam int MAX_PER  = (MAX_A > FAST_PER) ? MAX_A : FAST_PER;
  localparam int PH_W     = (MAX_PER > 2) ? $clog2(MAX_PER) : 1;

  pattern_e        patReg;
  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] lowCnt;
  logic [PH_W-1:0] lastPh;
  logic            blinking;

  always_comb begin
    lowCnt   = '0;
    lastPh   = '0;
    blinking = 1'b1;
    unique case (patReg)
      PAT_LONG: begin lowCnt = PH_W'(LONG_LOW); lastPh = PH_W'(LONG_PER - 1); end
      PAT_MED:  begin lowCnt = PH_W'(MED_LOW);  lastPh = PH_W'(MED_PER - 1);  end
      PAT_FAST: begin lowCnt = PH_W'(FAST_LOW); lastPh = PH_W'(FAST_PER - 1); end
      default:  blinking = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      patReg <= PAT_DARK;
      phase  <= '0;
    end else if (strobe.restart) begin
      patReg <= strobe.pattern;
      phase  <= '0;
    end else if (strobe.advance && blinking) begin
      phase <= (phase == lastPh) ? '0 : phase + PH_W'(1);
    end
  end

  always_comb begin
    unique case (patReg)
      PAT_LIT:  ledLow = 1'b1;
      PAT_DARK: ledLow = 1'b0;
      default:  ledLow = (phase < lowCnt);
    endcase
  end

endmodule

// File: rtl/charge_led_pattern.sv
module charge_led_pattern
  import ledpat_pkg::*;
#(
  parameter int LONG_LOW = 5,
  parameter int LONG_GAP = 1,
  parameter int MED_LOW  = 3,
  parameter int MED_GAP  = 3,
  parameter int FAST_LOW = 1,
  parameter int FAST_GAP = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tickUnit,
  input  logic [1:0] statusIn,
  input  logic [1:0] dispMode,
  output logic       ledPullLow,
  output logic       ledHiZ
);

  ledStrobe_t strobe;
  logic       ledLow;

  ledpat_ctrl #(.STATUS_W(2), .MODE_W(2)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .tickUnit (tickUnit),
    .statusIn (statusIn),
    .dispMode (dispMode),
    .strobe   (strobe)
  );

  ledpat_dp #(
    .LONG_LOW(LONG_LOW), .LONG_GAP(LONG_GAP),
    .MED_LOW (MED_LOW),  .MED_GAP (MED_GAP),
    .FAST_LOW(FAST_LOW), .FAST_GAP(FAST_GAP)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .ledLow (ledLow)
  );

  assign ledPullLow = ledLow;
  assign ledHiZ     = ~ledLow;

endmodule

// File: rtl/charge_led_pattern_chk.sv
module charge_led_pattern_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tickUnit,
  input logic [1:0] statusIn,
  input logic [1:0] dispMode,
  input logic       ledPullLow,
  input logic       ledHiZ
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_DARK: assert (ledHiZ && !ledPullLow); // R9
    end
  end

  AST_OUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({ledPullLow, ledHiZ})); // R2

  AST_NOBAT_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (statusIn == 2'd0) |=> ledHiZ); // R1

  AST_CHG_M0_LIT: assert property (@(posedge clk) disable iff (!rst_n)
    (statusIn == 2'd1 && dispMode == 2'd0) |=> ledPullLow); // R3

  AST_MAINT_M1_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (statusIn == 2'd2 && dispMode == 2'd1) |=> ledHiZ); // R4

  AST_MAINT_M2_LIT: assert property (@(posedge clk) disable iff (!rst_n)
    (statusIn == 2'd2 && dispMode == 2'd2) |=> ledPullLow); // R5

  AST_MODE3_MAINT_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (statusIn == 2'd2 && dispMode == 2'd3) |=> ledHiZ); // R6

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !tickUnit && $stable(statusIn) && $stable(dispMode)) |=> $stable(ledPullLow)); // R7

  AST_RESTART_LIT: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && statusIn == 2'd3 && $past(statusIn) != 2'd3) |=> ledPullLow); // R8

endmodule

bind charge_led_pattern charge_led_pattern_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tickUnit   (tickUnit),
  .statusIn   (statusIn),
  .dispMode   (dispMode),
  .ledPullLow (ledPullLow),
  .ledHiZ     (ledHiZ)
);

// File: tb/charge_led_pattern_bench.sv
module charge_led_pattern_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tickUnit = 1'b0;
  logic [1:0] statusIn = 2'd0;
  logic [1:0] dispMode = 2'd0;
  logic       ledPullLow;
  logic       ledHiZ;

  int    vecCnt = 0;
  int    errCnt = 0;
  bit    finished = 1'b0;
  string forceTag = "";

  logic [3:0] mSel = 4'd0;
  int         mPhase = 0;

  always #4 clk = ~clk;

  charge_led_pattern u_charge_led_pattern (
    .clk(clk), .rst_n(rst_n), .tickUnit(tickUnit),
    .statusIn(statusIn), .dispMode(dispMode),
    .ledPullLow(ledPullLow), .ledHiZ(ledHiZ)
  );

  // Pattern shape from the requirements: lit units, period in units
  function automatic void shapeOf(input logic [1:0] st, input logic [1:0] md,
                                  output int lowN, output int per);
    logic [1:0] m;
    m = (md == 2'd3) ? 2'd1 : md;
    lowN = 0; per = 1;
    case (st)
      2'd0: begin lowN = 0; per = 1; end
      2'd1: if (m == 2'd2) begin lowN = 5; per = 6; end else begin lowN = 1; per = 1; end
      2'd2: if (m == 2'd0) begin lowN = 5; per = 6; end
            else if (m == 2'd1) begin lowN = 0; per = 1; end
            else begin lowN = 1; per = 1; end
      default: if (m == 2'd0) begin lowN = 3; per = 6; end else begin lowN = 1; per = 2; end
    endcase
  endfunction

  function automatic string tagFor(input logic [1:0] st, input logic [1:0] md);
    if (st == 2'd0) return "R1";
    case (md)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic checkNow();
    int lowN, per;
    logic expLow;
    string tag;
    shapeOf(mSel[1:0], mSel[3:2], lowN, per);
    expLow = (mPhase < lowN);
    tag = (forceTag != "") ? forceTag : tagFor(mSel[1:0], mSel[3:2]);
    vecCnt++;
    if (ledPullLow !== expLow) begin
      errCnt++;
      $display("FAIL %s: ledPullLow=%0b expected %0b (status=%0d mode=%0d phase=%0d)",
               tag, ledPullLow, expLow, mSel[1:0], mSel[3:2], mPhase);
    end
    vecCnt++;
    if (ledHiZ !== ~ledPullLow) begin
      errCnt++;
      $display("FAIL R2: ledHiZ=%0b expected %0b", ledHiZ, ~ledPullLow);
    end
  endtask

  task automatic step(input logic t, input logic [1:0] st, input logic [1:0] md);
    int lowN, per;
    @(negedge clk);
    checkNow();
    tickUnit = t; statusIn = st; dispMode = md;
    if ({md, st} != mSel) begin
      mSel = {md, st};
      mPhase = 0;
    end else if (t) begin
      shapeOf(st, md, lowN, per);
      mPhase = (mPhase + 1) % per;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errCnt++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    statusIn = 2'd3; dispMode = 2'd2;
    repeat (3) begin
      @(negedge clk);
      vecCnt++;
      if (ledHiZ !== 1'b1 || ledPullLow !== 1'b0) begin
        errCnt++;
        $display("FAIL R9: ledHiZ=%0b ledPullLow=%0b expected 1 0", ledHiZ, ledPullLow);
      end
    end
    statusIn = 2'd0; dispMode = 2'd0;
    rst_n = 1'b1;

    // Sweep every status and mode pair over two full long periods
    for (int md = 0; md < 4; md++)
      for (int st = 0; st < 4; st++)
        for (int k = 0; k < 14; k++)
          step(1'b1, st[1:0], md[1:0]);

    // R7: mid-blink with no ticks the output must hold
    forceTag = "R7";
    step(1'b1, 2'd3, 2'd0);
    step(1'b1, 2'd3, 2'd0);
    step(1'b1, 2'd3, 2'd0);
    step(1'b1, 2'd3, 2'd0);
    for (int k = 0; k < 10; k++) step(1'b0, 2'd3, 2'd0);
    for (int k = 0; k < 4; k++) step(1'b1, 2'd3, 2'd0);
    for (int k = 0; k < 8; k++) step(k[0], 2'd2, 2'd0);

    // R8: change coincident with tick restarts lit; mode-only change too
    forceTag = "R8";
    for (int k = 0; k < 5; k++) step(1'b1, 2'd1, 2'd2);
    step(1'b1, 2'd3, 2'd2);
    for (int k = 0; k < 3; k++) step(1'b1, 2'd3, 2'd2);
    step(1'b1, 2'd3, 2'd0);
    for (int k = 0; k < 4; k++) step(1'b1, 2'd3, 2'd0);
    step(1'b1, 2'd3, 2'd3);
    for (int k = 0; k < 3; k++) step(1'b1, 2'd3, 2'd3);
    forceTag = "";

    // Random traffic
    begin
      logic [1:0] st, md;
      st = 2'd1; md = 2'd0;
      for (int k = 0; k < 3000; k++) begin
        if ($urandom_range(19) == 0) st = 2'($urandom_range(3));
        if ($urandom_range(39) == 0) md = 2'($urandom_range(3));
        step($urandom_range(2) == 0, st, md);
      end
    end
    step(1'b0, statusIn, dispMode);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

endmodule